// File: doc/BRIEF.md
# Two-Wire Slave Shift Unit with Start Stretch

This block is the shifting engine of a slave on a two-wire serial bus with a clock line and a data line. It brings both bus lines into the clock domain, detects a start condition and counts clock-line edges. Data is moved in and out through a shift register whose top bit sets the level the block puts on the data line. Both lines are open-drain: the block only asserts "pull low" enables, and the board's pull-ups provide the high level.

After a start, the block stretches the bus clock. It holds the clock line low from the master's next falling clock edge until software clears the start flag. This gives a slow or sleeping controller time to prepare before the address byte is shifted. A wrap of the edge counter stretches the clock in the same way, so software can handle each byte and each acknowledge slot. Address matching, acknowledge policy and stop handling are left to software, which uses a small write/read register port.

Register selects are 0 for the shift register, 1 for control and 2 for status. Control bits are: bit 0 enables the data-line output, bit 1 enables the clock-line output, bit 2 enables the start interrupt and bit 3 enables the overflow interrupt. In the status register, bit 7 is the start flag, bit 6 is the overflow flag and bits 3:0 hold the edge counter.

Top module: `tw_shift_slave`

## Requirements
- R1: The start flag (status bit 7) is set only when the synchronised data line falls while the synchronised clock line is high in both the current and the previous sample. A data-line fall with the clock low does not set it, and neither does a data-line rise with the clock high.
- R2: `irq_o` is high exactly when (start flag AND control bit 2) OR (overflow flag AND control bit 3).
- R3: With control bit 1 set, the first falling clock-line edge after the start flag is set makes `scl_low_o` go high. The output stays high while the master releases the clock. With control bit 1 clear, `scl_low_o` stays low.
- R4: A status write with bit 7 at one clears the start flag and ends the start stretch. Every status write loads bits 3:0 into the edge counter.
- R5: On each rising clock-line edge, the shift register moves left by one bit and takes the sampled data line into bit 0. A write to select 0 loads the register, and select 0 reads it back.
- R6: The edge counter increases by one on every rising and every falling clock-line edge. When it wraps from 15 to 0, the overflow flag (status bit 6) is set. While that flag is set and control bit 1 is one, the clock line is held low.
- R7: `sda_low_o` is high only when control bit 0 is one and the output bit is zero. The output bit takes shift register bit 7 when the register is written and on each falling clock-line edge. As a result, a byte is sent MSB first.
- R8: Flags clear only when a one is written to their status bit. A status write with zero in a flag bit leaves that flag unchanged.
- R9: After reset, both line outputs and `irq_o` are low, the control and status registers read zero, and the shift register reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_pad_i | input | 1 | Clock line level seen at the pad |
| sda_pad_i | input | 1 | Data line level seen at the pad |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 shift, 1 control, 2 status |
| wr_data_i | input | DATA_W | Write value |
| rd_sel_i | input | 2 | Read source: 0 shift, 1 control, 2 status |
| rd_data_o | output | DATA_W | Read value for the selected register |
| sda_low_o | output | 1 | Pull the data line low |
| scl_low_o | output | 1 | Pull the clock line low |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- a start flag only rises after a detected start;
- a stretch always has a set flag behind it, and the clock line is released once both flags are clear;
- an overflow only appears on a 15-to-0 wrap;
- a disabled output never pulls its line.

The bench scenarios are needed for the behaviour that spans whole frames:
- the bit order of received and transmitted bytes, which is swept over all 256 values;
- the exact edge count while the master's rising edge is masked by a stretch;
- the rejection of data-line transitions made with the clock low or as a stop.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [1:0] {
        SEL_SHIFT = 2'd0,
        SEL_CTRL  = 2'd1,
        SEL_STAT  = 2'd2
    } reg_sel_e;

    localparam int CTRL_SDA_OE   = 0;
    localparam int CTRL_SCL_OE   = 1;
    localparam int CTRL_START_IE = 2;
    localparam int CTRL_OVF_IE   = 3;
    localparam int CTRL_BITS     = 4;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/tw_edge_det.sv
module tw_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s_i,
    input  logic sda_s_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_q, prev_d;

    always_comb begin
        prev_d     = prev_q;
        prev_d.scl = scl_s_i;
        prev_d.sda = sda_s_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= prev_d;
    end

    // Clock must be high in both samples so a data change made while
    // the clock was low, then seen together with a clock rise, is not a start.
    assign scl_rise_o = scl_s_i & ~prev_q.scl;
    assign scl_fall_o = ~scl_s_i & prev_q.scl;
    assign start_o    = scl_s_i & prev_q.scl & prev_q.sda & ~sda_s_i;

endmodule

// File: rtl/tw_shift_slave.sv
module tw_shift_slave
    import tw_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_pad_i,
    input  logic              sda_pad_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [1:0]        rd_sel_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              sda_low_o,
    output logic              scl_low_o,
    output logic              irq_o
);

    localparam int STAT_START_BIT = DATA_W - 1;
    localparam int STAT_OVF_BIT   = DATA_W - 2;

    typedef struct packed {
        logic [DATA_W-1:0] shreg;
        logic              sda_out;
        logic [CNT_W-1:0]  cnt;
        logic              start_flag;
        logic              start_hold;
        logic              ovf_flag;
        logic              sda_oe;
        logic              scl_oe;
        logic              start_ie;
        logic              ovf_ie;
    } state_t;

    localparam state_t ST_RST = '{shreg: '1, sda_out: 1'b1, default: '0};

    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_det;

    tw_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync_scl (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (scl_pad_i),
        .q_o   (scl_s)
    );

    tw_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync_sda (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (sda_pad_i),
        .q_o   (sda_s)
    );

    tw_edge_det i_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s_i    (scl_s),
        .sda_s_i    (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det)
    );

    state_t          st_q, st_d;
    logic [CNT_W:0]  cnt_inc;
    logic            wr_shift, wr_ctrl, wr_stat;

    always_comb begin
        st_d     = st_q;
        wr_shift = wr_en_i && (wr_sel_i == SEL_SHIFT);
        wr_ctrl  = wr_en_i && (wr_sel_i == SEL_CTRL);
        wr_stat  = wr_en_i && (wr_sel_i == SEL_STAT);
        cnt_inc  = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, 1'b1};

        // bus events
        if (scl_rise) begin
            st_d.shreg = {st_q.shreg[DATA_W-2:0], sda_s};
        end
        if (scl_fall) begin
            st_d.sda_out = st_q.shreg[DATA_W-1];
        end
        if ((scl_rise || scl_fall) && !wr_stat) begin
            st_d.cnt = cnt_inc[CNT_W-1:0];
            if (cnt_inc[CNT_W]) begin
                st_d.ovf_flag = 1'b1;
            end
        end
        if (start_det) begin
            st_d.start_flag = 1'b1;
        end
        if (st_q.start_flag && scl_fall) begin
            st_d.start_hold = 1'b1;
        end

        // software writes take precedence over bus events
        if (wr_shift) begin
            st_d.shreg   = wr_data_i;
            st_d.sda_out = wr_data_i[DATA_W-1];
        end
        if (wr_ctrl) begin
            st_d.sda_oe   = wr_data_i[CTRL_SDA_OE];
            st_d.scl_oe   = wr_data_i[CTRL_SCL_OE];
            st_d.start_ie = wr_data_i[CTRL_START_IE];
            st_d.ovf_ie   = wr_data_i[CTRL_OVF_IE];
        end
        if (wr_stat) begin
            st_d.cnt = wr_data_i[CNT_W-1:0];
            if (wr_data_i[STAT_START_BIT]) begin
                st_d.start_flag = 1'b0;
                st_d.start_hold = 1'b0;
            end
            if (wr_data_i[STAT_OVF_BIT]) begin
                st_d.ovf_flag = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign sda_low_o = st_q.sda_oe & ~st_q.sda_out;
    assign scl_low_o = st_q.scl_oe & (st_q.start_hold | st_q.ovf_flag);
    assign irq_o     = (st_q.start_flag & st_q.start_ie) | (st_q.ovf_flag & st_q.ovf_ie);

    always_comb begin
        rd_data_o = '0;
        case (rd_sel_i)
            SEL_SHIFT: rd_data_o = st_q.shreg;
            SEL_CTRL: begin
                rd_data_o[CTRL_SDA_OE]   = st_q.sda_oe;
                rd_data_o[CTRL_SCL_OE]   = st_q.scl_oe;
                rd_data_o[CTRL_START_IE] = st_q.start_ie;
                rd_data_o[CTRL_OVF_IE]   = st_q.ovf_ie;
            end
            SEL_STAT: begin
                rd_data_o[CNT_W-1:0]     = st_q.cnt;
                rd_data_o[STAT_START_BIT] = st_q.start_flag;
                rd_data_o[STAT_OVF_BIT]   = st_q.ovf_flag;
            end
            default: rd_data_o = '0;
        endcase
    end

    // named views for the bound checker
    logic             start_flag_w, start_hold_w, ovf_flag_w, sda_oe_w, scl_oe_w;
    logic [CNT_W-1:0] cnt_w;
    assign start_flag_w = st_q.start_flag;
    assign start_hold_w = st_q.start_hold;
    assign ovf_flag_w   = st_q.ovf_flag;
    assign sda_oe_w     = st_q.sda_oe;
    assign scl_oe_w     = st_q.scl_oe;
    assign cnt_w        = st_q.cnt;

endmodule

// File: rtl/tw_shift_chk.sv
module tw_shift_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_flag,
    input logic             start_hold,
    input logic             ovf_flag,
    input logic             sda_oe,
    input logic             scl_oe,
    input logic [CNT_W-1:0] cnt,
    input logic             start_det,
    input logic             scl_fall,
    input logic             sda_low,
    input logic             scl_low,
    input logic             irq
);

    p_start_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_flag) |-> $past(start_det));

    p_irq_has_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (start_flag || ovf_flag));

    p_hold_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_flag && scl_fall) |=> (start_hold || !start_flag));

    p_no_oe_no_stretch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !scl_oe |-> !scl_low);

    p_hold_needs_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_hold |-> start_flag);

    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_flag && !ovf_flag) |-> !scl_low);

    p_ovf_on_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($past(cnt) == '1 && cnt == '0));

    p_sda_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sda_oe |-> !sda_low);

endmodule

bind tw_shift_slave tw_shift_chk #(.CNT_W(CNT_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_flag (start_flag_w),
    .start_hold (start_hold_w),
    .ovf_flag   (ovf_flag_w),
    .sda_oe     (sda_oe_w),
    .scl_oe     (scl_oe_w),
    .cnt        (cnt_w),
    .start_det  (start_det),
    .scl_fall   (scl_fall),
    .sda_low    (sda_low_o),
    .scl_low    (scl_low_o),
    .irq        (irq_o)
);

// File: tb/test_tw_shift_slave.sv
module test_tw_shift_slave;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_sel = 2'd0;
    logic [7:0] rd_data;
    logic       sda_low, scl_low, irq;
    logic       scl_line, sda_line;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign scl_line = m_scl & ~scl_low;
    assign sda_line = m_sda & ~sda_low;

    tw_shift_slave i_tw_shift_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_pad_i (scl_line),
        .sda_pad_i (sda_line),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .rd_sel_i  (rd_sel),
        .rd_data_o (rd_data),
        .sda_low_o (sda_low),
        .scl_low_o (scl_low),
        .irq_o     (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
        idle(1);
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] val);
        rd_sel = sel;
        #1;
        val = rd_data;
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        logic [7:0] v;
        logic [7:0] got;

        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R9 reset state
        rd(2'd0, v); chk("R9 shift reset", v, 8'hFF);
        rd(2'd1, v); chk("R9 ctrl reset", v, 0);
        rd(2'd2, v); chk("R9 status reset", v, 0);
        chk("R9 sda released", sda_low, 0);
        chk("R9 scl released", scl_low, 0);
        chk("R9 irq low", irq, 0);

        // start handling, scl output and start interrupt enabled
        wr(2'd1, 8'h06);
        m_scl = 1'b0; idle(6);
        m_sda = 1'b0; idle(6);
        rd(2'd2, v); chk("R1 sda fall with scl low ignored", v[7], 0);
        m_sda = 1'b1; idle(6);
        m_scl = 1'b1; idle(6);
        rd(2'd2, v); chk("R1 no start from clock rise", v[7], 0);
        wr(2'd2, 8'hC0);
        m_sda = 1'b0; idle(6);
        rd(2'd2, v); chk("R1 start flag set", v[7], 1);
        chk("R2 start irq", irq, 1);
        chk("R3 no stretch before fall", scl_low, 0);
        wr(2'd2, 8'h00);
        rd(2'd2, v); chk("R8 zero write keeps start flag", v[7], 1);
        m_scl = 1'b0; idle(6);
        chk("R3 stretch after first fall", scl_low, 1);
        m_scl = 1'b1; idle(6);
        chk("R3 clock line held low", scl_line, 0);
        rd(2'd2, v); chk("R6 only the fall counted", v[3:0], 1);
        wr(2'd2, 8'h80); idle(5);
        chk("R4 stretch released", scl_low, 0);
        chk("R2 irq drops with flag", irq, 0);
        rd(2'd2, v); chk("R4 start flag cleared", v[7], 0);
        chk("R6 release edge counted after load", v[3:0], 1);
        m_sda = 1'b1; idle(6);
        rd(2'd2, v); chk("R1 stop not a start", v[7], 0);

        // start interrupt disabled
        wr(2'd1, 8'h02);
        m_sda = 1'b0; idle(6);
        rd(2'd2, v); chk("R1 start flag with irq off", v[7], 1);
        chk("R2 irq masked", irq, 0);
        wr(2'd2, 8'h80);
        m_sda = 1'b1; idle(6);

        // clock output disabled: no stretch
        wr(2'd1, 8'h00);
        m_sda = 1'b0; idle(6);
        m_scl = 1'b0; idle(6);
        chk("R3 no stretch without scl enable", scl_low, 0);
        wr(2'd2, 8'hC0);

        // counter preload and overflow
        wr(2'd1, 8'h08);
        wr(2'd2, 8'h0E);
        m_scl = 1'b1; idle(6);
        rd(2'd2, v); chk("R4 counter load then edge", v, 8'h0F);
        m_scl = 1'b0; idle(6);
        rd(2'd2, v); chk("R6 wrap sets overflow", v, 8'h40);
        chk("R2 overflow irq", irq, 1);
        chk("R6 no stretch without scl enable", scl_low, 0);
        wr(2'd1, 8'h0A);
        chk("R6 overflow stretch", scl_low, 1);
        wr(2'd2, 8'h40);
        chk("R8 overflow cleared releases", scl_low, 0);
        chk("R2 irq off after clear", irq, 0);

        // data-line output enable
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h00);
        chk("R7 disabled output never pulls", sda_low, 0);
        wr(2'd1, 8'h01);
        chk("R7 bit7 zero pulls low", sda_low, 1);
        wr(2'd0, 8'h80);
        chk("R7 bit7 one releases", sda_low, 0);

        // receive sweep over all byte values
        wr(2'd1, 8'h02);
        for (int b = 0; b < 256; b++) begin
            wr(2'd2, 8'hC0);
            for (int i = 7; i >= 0; i--) begin
                m_sda = b[i]; idle(6);
                m_scl = 1'b1; idle(6);
                m_scl = 1'b0; idle(6);
            end
            rd(2'd0, v); chk("R5 received byte", v, b);
            rd(2'd2, v); chk("R6 overflow after 16 edges", {v[6], scl_low}, 2'b11);
        end

        // transmit sweep over all byte values
        m_sda = 1'b1;
        wr(2'd1, 8'h03);
        for (int b = 0; b < 256; b++) begin
            wr(2'd0, b[7:0]);
            wr(2'd2, 8'hC0);
            got = 8'h00;
            for (int i = 7; i >= 0; i--) begin
                idle(6);
                m_scl = 1'b1; idle(6);
                got[i] = sda_line;
                m_scl = 1'b0;
            end
            idle(6);
            chk("R7 transmitted MSB first", got, b);
            rd(2'd0, v); chk("R5 shifted own output back", v, b);
        end

        summary();
    end

endmodule